// File: doc/BRIEF.md
# GPIO Port with External Bus Override

An eight-pin general-purpose I/O port for a pad ring of tri-state pads. Software sees two registers on a small register bus: an output latch and a per-pin direction register. In plain GPIO operation each direction bit selects whether its pad drives the latched value or floats as an input. Input levels reach the read path and a bus-side tap through a multi-flop synchronizer.

An external bus controller can take ownership of the pins. While it owns them, it supplies both the pad enables and the pad output values. The stored direction bits keep their value and can still be read and written, but they no longer reach the pads. In emulation mode the bus also owns the pins. In addition, every register read returns data from the external bus, and every register write is stored locally and copied to the bus in the same cycle.

The ownership mode is held in a three-state machine: `PM_GPIO`, `PM_BUS` and `PM_EMU`. Emulation requests win over bus requests. The named transitions are:
- take (GPIO to BUS) and release (BUS to GPIO);
- enter-emulation (GPIO or BUS to EMU);
- leave-to-bus (EMU to BUS) and leave-to-GPIO (EMU to GPIO).

Top module: `gpio_bus_port`

## Requirements
- R1: After reset the output latch, the direction register and the synchronizer are all zero, and the mode is `PM_GPIO`. So `pad_oe` and `pad_out` are 0.
- R2: `reg_addr` 0 selects the output latch and `reg_addr` 1 selects the direction register. A write with `reg_we` high is stored on the next rising clock edge in every mode. Reads are combinational from current state.
- R3: In `PM_GPIO`, `pad_oe` equals the direction register (1 = drive, 0 = high-impedance input) and `pad_out` equals the output latch.
- R4: Outside `PM_EMU`, a read of address 0 returns, per bit, the latch value where the direction bit is 1 and the synchronized pin level where it is 0. A read of address 1 returns the direction register.
- R5: A pad input change reaches the read path and `xbus_pin` exactly `SYNC_STAGES` rising edges later.
- R6: In `PM_BUS` and `PM_EMU`, `pad_oe` equals `xbus_dir` and `pad_out` equals `xbus_dout`. The direction register keeps its stored value and changes only through register writes.
- R7: In `PM_EMU`, every register read returns `xbus_rdata`, whatever the address.
- R8: In `PM_EMU`, `xbus_wr` follows `reg_we` in the same cycle, with `xbus_waddr` and `xbus_wdata` copied from the register bus. Outside `PM_EMU`, `xbus_wr` is 0.
- R9: The mode register is loaded on each rising edge as follows: `mode_emu` high gives `PM_EMU`; otherwise `mode_bus` high gives `PM_BUS`; otherwise it gives `PM_GPIO`. A mode input change therefore acts one edge later.
- R10: A write to the output latch is stored even while its pins are inputs. It appears on `pad_out` at once, and it appears on reads when the direction is later set to output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 1 | Register select: 0 latch, 1 direction |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | WIDTH | Register write data |
| reg_rdata | output | WIDTH | Register read data |
| pad_in | input | WIDTH | Pad input levels |
| pad_out | output | WIDTH | Pad output values |
| pad_oe | output | WIDTH | Pad output enables, 1 = drive |
| mode_bus | input | 1 | External bus requests pin ownership |
| mode_emu | input | 1 | Emulation mode request |
| xbus_dir | input | WIDTH | Bus-supplied pin directions |
| xbus_dout | input | WIDTH | Bus-supplied pin output values |
| xbus_rdata | input | WIDTH | Bus data returned on reads in emulation |
| xbus_pin | output | WIDTH | Synchronized pin levels for the bus |
| xbus_wr | output | 1 | Forwarded write strobe |
| xbus_waddr | output | 1 | Forwarded write address |
| xbus_wdata | output | WIDTH | Forwarded write data |

## Verification
The bench builds the port with `WIDTH` = 8 and `SYNC_STAGES` = 2. These values put the two-edge input latency and each mixed per-bit direction pattern within reach of both random stimulus and directed checks. Random cycles mix all three modes with writes to both registers. This covers every named mode transition, including both mode requests raised together. It also covers writes landing while the pins are owned by the bus.

// File: rtl/pio_pkg.sv
package pio_pkg;
    typedef enum logic [1:0] {
        PM_GPIO = 2'd0,
        PM_BUS  = 2'd1,
        PM_EMU  = 2'd2
    } pio_mode_e;

    localparam logic SEL_LATCH = 1'b0;
    localparam logic SEL_DIR   = 1'b1;
endpackage

// File: rtl/pio_mode_fsm.sv
module pio_mode_fsm
    import pio_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bus_req,
    input  logic      emu_req,
    output pio_mode_e mode_q,
    output logic      bus_owns,
    output logic      emu_active
);
    pio_mode_e mode_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= PM_GPIO;
        else        mode_q <= mode_d;
    end

    // next state: emulation request outranks bus request
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            PM_GPIO: begin
                if (emu_req)      mode_d = PM_EMU;   // enter-emulation
                else if (bus_req) mode_d = PM_BUS;   // take
            end
            PM_BUS: begin
                if (emu_req)      mode_d = PM_EMU;   // enter-emulation
                else if (!bus_req) mode_d = PM_GPIO; // release
            end
            PM_EMU: begin
                if (!emu_req) begin
                    if (bus_req) mode_d = PM_BUS;    // leave-to-bus
                    else         mode_d = PM_GPIO;   // leave-to-GPIO
                end
            end
            default: mode_d = PM_GPIO;
        endcase
    end

    // outputs
    always_comb begin
        bus_owns   = 1'b0;
        emu_active = 1'b0;
        unique case (mode_q)
            PM_GPIO: ;
            PM_BUS:  bus_owns = 1'b1;
            PM_EMU: begin
                bus_owns   = 1'b1;
                emu_active = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[LAST];
endmodule

// File: rtl/pio_regs.sv
module pio_regs
    import pio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             sel,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] dir_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
        end else if (we) begin
            if (sel == SEL_LATCH) latch_q <= wdata;
            else                  dir_q   <= wdata;
        end
    end
endmodule

// File: rtl/gpio_bus_port.sv
module gpio_bus_port
    import pio_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_addr,
    input  logic             reg_we,
    input  logic [WIDTH-1:0] reg_wdata,
    output logic [WIDTH-1:0] reg_rdata,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    input  logic             mode_bus,
    input  logic             mode_emu,
    input  logic [WIDTH-1:0] xbus_dir,
    input  logic [WIDTH-1:0] xbus_dout,
    input  logic [WIDTH-1:0] xbus_rdata,
    output logic [WIDTH-1:0] xbus_pin,
    output logic             xbus_wr,
    output logic             xbus_waddr,
    output logic [WIDTH-1:0] xbus_wdata
);
    pio_mode_e        mode_q;
    logic             bus_owns;
    logic             emu_active;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] pin_s;
    logic [WIDTH-1:0] port_view;

    pio_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_req    (mode_bus),
        .emu_req    (mode_emu),
        .mode_q     (mode_q),
        .bus_owns   (bus_owns),
        .emu_active (emu_active)
    );

    pio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .sel     (reg_addr),
        .wdata   (reg_wdata),
        .latch_q (latch_q),
        .dir_q   (dir_q)
    );

    pio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_s)
    );

    // pad side: bus ownership replaces stored direction and latch
    assign pad_oe   = bus_owns ? xbus_dir  : dir_q;
    assign pad_out  = bus_owns ? xbus_dout : latch_q;
    assign xbus_pin = pin_s;

    // per-bit read source: latch for outputs, pin for inputs
    assign port_view = (dir_q & latch_q) | (~dir_q & pin_s);

    always_comb begin
        if (emu_active)              reg_rdata = xbus_rdata;
        else if (reg_addr == SEL_DIR) reg_rdata = dir_q;
        else                         reg_rdata = port_view;
    end

    // write mirroring toward the external bus
    assign xbus_wr    = emu_active & reg_we;
    assign xbus_waddr = reg_addr;
    assign xbus_wdata = reg_wdata;
endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk
    import pio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_addr,
    input logic             reg_we,
    input logic [WIDTH-1:0] reg_wdata,
    input logic [WIDTH-1:0] reg_rdata,
    input logic             mode_bus,
    input logic             mode_emu,
    input logic [WIDTH-1:0] xbus_dir,
    input logic [WIDTH-1:0] xbus_rdata,
    input logic [WIDTH-1:0] pad_oe,
    input logic             xbus_wr,
    input pio_mode_e        mode_q,
    input logic [WIDTH-1:0] latch_q,
    input logic [WIDTH-1:0] dir_q
);
    AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == SEL_LATCH) |=> latch_q == $past(reg_wdata)); // R2
    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == SEL_DIR) |=> $stable(dir_q)); // R6
    AST_BUS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bus && !mode_emu) |=> pad_oe == xbus_dir); // R6
    AST_EMU_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mode_emu |=> reg_rdata == xbus_rdata); // R7
    AST_FWD_ONLY_EMU: assert property (@(posedge clk) disable iff (!rst_n)
        xbus_wr |-> (mode_q == PM_EMU && reg_we)); // R8
    AST_EMU_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        mode_emu |=> mode_q == PM_EMU); // R9
    AST_GPIO_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_emu && !mode_bus) |=> mode_q == PM_GPIO); // R9
endmodule

bind gpio_bus_port pio_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_we     (reg_we),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .mode_bus   (mode_bus),
    .mode_emu   (mode_emu),
    .xbus_dir   (xbus_dir),
    .xbus_rdata (xbus_rdata),
    .pad_oe     (pad_oe),
    .xbus_wr    (xbus_wr),
    .mode_q     (mode_q),
    .latch_q    (latch_q),
    .dir_q      (dir_q)
);

// File: tb/tb_gpio_bus_port.sv
`timescale 1ns/1ps
module tb_gpio_bus_port;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_addr = 1'b0;
    logic         reg_we = 1'b0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] pad_out;
    logic [W-1:0] pad_oe;
    logic         mode_bus = 1'b0;
    logic         mode_emu = 1'b0;
    logic [W-1:0] xbus_dir = '0;
    logic [W-1:0] xbus_dout = '0;
    logic [W-1:0] xbus_rdata = '0;
    logic [W-1:0] xbus_pin;
    logic         xbus_wr;
    logic         xbus_waddr;
    logic [W-1:0] xbus_wdata;

    always #2 clk = ~clk;

    gpio_bus_port #(.WIDTH(W), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .mode_bus(mode_bus),
        .mode_emu(mode_emu), .xbus_dir(xbus_dir), .xbus_dout(xbus_dout),
        .xbus_rdata(xbus_rdata), .xbus_pin(xbus_pin), .xbus_wr(xbus_wr),
        .xbus_waddr(xbus_waddr), .xbus_wdata(xbus_wdata)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference state: 0 gpio, 1 bus, 2 emulation
    int           m_mode = 0;
    logic [W-1:0] m_latch = '0;
    logic [W-1:0] m_dir = '0;
    logic [W-1:0] m_s1 = '0;
    logic [W-1:0] m_s2 = '0;

    function automatic logic [W-1:0] exp_rdata();
        if (m_mode == 2) return xbus_rdata;
        if (reg_addr) return m_dir;
        return (m_dir & m_latch) | (~m_dir & m_s2);
    endfunction

    function automatic logic [W-1:0] exp_oe();
        return (m_mode == 0) ? m_dir : xbus_dir;
    endfunction

    function automatic logic [W-1:0] exp_out();
        return (m_mode == 0) ? m_latch : xbus_dout;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(pad_oe == exp_oe(), (m_mode == 0) ? "R3 pad_oe" : "R6 pad_oe",
            int'(pad_oe), int'(exp_oe()));
        chk(pad_out == exp_out(), (m_mode == 0) ? "R3 pad_out" : "R6 pad_out",
            int'(pad_out), int'(exp_out()));
        chk(reg_rdata == exp_rdata(), (m_mode == 2) ? "R7 read" : "R4 read",
            int'(reg_rdata), int'(exp_rdata()));
        chk(xbus_pin == m_s2, "R5 xbus_pin", int'(xbus_pin), int'(m_s2));
        chk(xbus_wr == (m_mode == 2 && reg_we), "R8 xbus_wr",
            int'(xbus_wr), int'(m_mode == 2 && reg_we));
        if (xbus_wr)
            chk(xbus_wdata == reg_wdata && xbus_waddr == reg_addr, "R8 forward",
                int'(xbus_wdata), int'(reg_wdata));
    endtask

    // one rising edge, update the reference, then compare at the falling edge
    task automatic tick();
        @(posedge clk);
        if (reg_we) begin
            if (reg_addr) m_dir = reg_wdata;
            else          m_latch = reg_wdata;
        end
        m_s2 = m_s1;
        m_s1 = pad_in;
        m_mode = mode_emu ? 2 : (mode_bus ? 1 : 0);
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input logic a, input logic [W-1:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        tick();
        reg_we = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(pad_oe == '0 && pad_out == '0, "R1 pads", int'({pad_oe, pad_out}), 0);
        reg_addr = 1'b1; #1;
        chk(reg_rdata == '0, "R1 dir", int'(reg_rdata), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 latch written while pins are inputs
        wr(1'b0, 8'hA5);
        chk(pad_out == 8'hA5 && pad_oe == 8'h00, "R10 pad_out", int'(pad_out), 'hA5);
        wr(1'b1, 8'hFF);
        reg_addr = 1'b0; #1;
        chk(reg_rdata == 8'hA5, "R10 read", int'(reg_rdata), 'hA5);

        // R2 direction readback, mixed pattern
        wr(1'b1, 8'h0F);
        reg_addr = 1'b1; #1;
        chk(reg_rdata == 8'h0F, "R2 dir read", int'(reg_rdata), 'h0F);

        // R5 input latency, pins 7..4 are inputs
        reg_addr = 1'b0; pad_in = 8'h90;
        tick();
        chk(reg_rdata == 8'h05, "R5 one edge", int'(reg_rdata), 'h05);
        tick();
        chk(reg_rdata == 8'h95, "R5 two edges", int'(reg_rdata), 'h95);

        // R6 bus override keeps stored direction
        mode_bus = 1'b1; xbus_dir = 8'h3C; xbus_dout = 8'h66;
        tick();
        chk(pad_oe == 8'h3C && pad_out == 8'h66, "R6 override",
            int'({pad_oe, pad_out}), 'h3C66);
        reg_addr = 1'b1; #1;
        chk(reg_rdata == 8'h0F, "R6 dir kept", int'(reg_rdata), 'h0F);
        mode_bus = 1'b0;
        tick();
        chk(pad_oe == 8'h0F, "R6 release", int'(pad_oe), 'h0F);

        // R9 emulation outranks bus, one edge later
        mode_bus = 1'b1; mode_emu = 1'b1; xbus_rdata = 8'hC3; #1;
        chk(reg_rdata == 8'h0F, "R9 before edge", int'(reg_rdata), 'h0F);
        tick();
        chk(reg_rdata == 8'hC3, "R9 emu wins", int'(reg_rdata), 'hC3);

        // R8 forwarded write, also stored
        reg_addr = 1'b0; reg_wdata = 8'h5A; reg_we = 1'b1; #1;
        chk(xbus_wr && xbus_wdata == 8'h5A && !xbus_waddr, "R8 mirror",
            int'(xbus_wdata), 'h5A);
        tick();
        reg_we = 1'b0; mode_emu = 1'b0; mode_bus = 1'b0;
        tick();
        chk(pad_out == 8'h5A, "R8 stored", int'(pad_out), 'h5A);

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            reg_addr   = 1'($urandom_range(0, 1));
            reg_we     = ($urandom_range(0, 2) == 0);
            reg_wdata  = 8'($urandom());
            pad_in     = 8'($urandom());
            mode_emu   = ($urandom_range(0, 4) == 0);
            mode_bus   = ($urandom_range(0, 1) == 1);
            xbus_dir   = 8'($urandom());
            xbus_dout  = 8'($urandom());
            xbus_rdata = 8'($urandom());
            #1;
            compare_all();
            tick();
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule